// File: doc/BRIEF.md
# Serial Register Slave with Write Trace

This block is a serial peripheral slave that exposes a small bank of byte-wide registers to an external host. The host frames each access with an active-low chip select and sends three bytes, most significant bit first: a command byte, a register address byte, and one data byte. On a write command the data byte arrives on the input line and is stored at the addressed register. On a read command the slave drives the addressed register's contents on its output line during the third byte. The output enable is low at every other time.

Every write also records its received address and data byte in two read-only trace registers. These sit at two fixed addresses set by parameters. The host can read them back after each write to confirm that the transfer arrived intact. Only the most recent write is kept.

The serial clock, chip select and input line are brought into the system clock domain through two-flop synchronisers. Input bits are taken on the rising serial clock edge and output bits change on the falling edge (mode 0). The system clock must run several times faster than the serial clock.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset both trace registers read as 0x00 and the output enable is low.
- R2: Command 0x02 stores the third byte, received most significant bit first, into the bank register selected by the second byte.
- R3: Command 0x03 drives the addressed register's contents on the output line during the third byte, most significant bit first. Each bit is set after a falling serial clock edge and held through the following high phase.
- R4: The output enable is low during the command and address bytes, for the whole of any write frame, and after the frame ends.
- R5: Every completed write copies its address byte into the address trace register (default address 0xFE) and its data byte into the data trace register (default address 0xFF). Both can be read with command 0x03.
- R6: A write aimed at either trace address changes nothing except the trace capture itself. A later read of the address trace returns that trace address, and a read of the data trace returns the written byte.
- R7: A command byte other than 0x02 or 0x03 changes no register and no trace register, and the output enable stays low for the whole frame.
- R8: If chip select rises before all 24 bits have been received, the frame is dropped with no register or trace update, and the next frame is decoded from its first bit.
- R9: An address that is neither in the bank (at or above the bank depth) nor a trace address reads as 0x00. A write to such an address updates only the trace registers and does not alias onto any bank register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host; meaningful only while miso_oe_o is high |
| miso_oe_o | output | 1 | Output enable for the serial data line; low means high-impedance |

## Verification
The two functions that land in the same system clock cycle are the bank write and the trace capture. Both fire on the commit pulse at the 24th rising edge. When the target is a trace address, the bank's write rule and the capture touch the same register. The bench provokes this by sweeping writes over every bank address and both trace addresses, then reading the trace registers and the bank back. The capture must win, and the bank and the other addresses must stay unchanged.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 3;
  localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
  localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_READ  = 8'h03;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= RST_VAL[i];
        stab_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              miso_o,
  output logic              oe_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ADR_LAST  = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] DAT_START = CNT_W'(2 * BYTE_W);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] BIT_END   = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, sh_next;
  logic [BYTE_W-1:0] cmd_q, adr_q, tx_q;
  logic              oe_q, miso_q, wr_q;
  logic [BYTE_W-1:0] wa_q, wd_q;

  assign sh_next = {sh_q[BYTE_W-2:0], mosi_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      cmd_q  <= '0;
      adr_q  <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
      miso_q <= 1'b0;
      wr_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      wr_q <= 1'b0;
      if (!active_i) begin
        cnt_q  <= '0;
        oe_q   <= 1'b0;
        miso_q <= 1'b0;
      end else begin
        if (rise_i && cnt_q < BIT_END) begin
          cnt_q <= cnt_q + 1'b1;
          sh_q  <= sh_next;
          if (cnt_q == CMD_LAST) cmd_q <= sh_next;
          if (cnt_q == ADR_LAST) adr_q <= sh_next;
          if (cnt_q == BIT_LAST && cmd_q == CMD_WRITE) begin
            wr_q <= 1'b1;
            wa_q <= adr_q;
            wd_q <= sh_next;
          end
        end
        if (fall_i) begin
          if (cnt_q == DAT_START && cmd_q == CMD_READ) begin
            miso_q <= rd_data_i[BYTE_W-1];
            tx_q   <= {rd_data_i[BYTE_W-2:0], 1'b0};
            oe_q   <= 1'b1;
          end else if (cnt_q == BIT_END) begin
            oe_q <= 1'b0;
          end else if (cnt_q > DAT_START && oe_q) begin
            miso_q <= tx_q[BYTE_W-1];
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign rd_addr_o = adr_q;
  assign wr_en_o   = wr_q;
  assign wr_addr_o = wa_q;
  assign wr_data_o = wd_q;
  assign miso_o    = miso_q;
  assign oe_o      = oe_q;

  // R4: never drive before the data byte has begun
  assert_hiz_head_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < DAT_START) |-> !oe_q);
  // R7: only a read command may enable the output
  assert_oe_read_only_R7: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (cmd_q == CMD_READ));
  // R8: a commit only follows a full frame under select
  assert_commit_full_R8: assert property (@(posedge clk) disable iff (rst)
    wr_q |-> (cnt_q == BIT_END));
  // R2: a commit requires the write command
  assert_commit_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    wr_q |-> (cmd_q == CMD_WRITE));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter logic [BYTE_W-1:0] TRC_ADDR_LOC = 8'hFE,
  parameter logic [BYTE_W-1:0] TRC_DATA_LOC = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [BYTE_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [BYTE_W:0] DEPTH_V = (BYTE_W+1)'(DEPTH);

  typedef enum logic [1:0] {SEL_MEM, SEL_TA, SEL_TD, SEL_NONE} rd_sel_e;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] mem_q;
  logic [BYTE_W-1:0] trc_a_q, trc_d_q;
  rd_sel_e           sel_q, sel_d;
  logic              wr_in_bank;

  assign wr_in_bank = ({1'b0, wr_addr_i} < DEPTH_V) &&
                      (wr_addr_i != TRC_ADDR_LOC) && (wr_addr_i != TRC_DATA_LOC);

  always_ff @(posedge clk) begin
    if (wr_en_i && wr_in_bank) mem[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
    mem_q <= mem[rd_addr_i[IDX_W-1:0]];
  end

  always_comb begin
    if (rd_addr_i == TRC_ADDR_LOC)               sel_d = SEL_TA;
    else if (rd_addr_i == TRC_DATA_LOC)          sel_d = SEL_TD;
    else if ({1'b0, rd_addr_i} < DEPTH_V)        sel_d = SEL_MEM;
    else                                         sel_d = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trc_a_q <= '0;
      trc_d_q <= '0;
      sel_q   <= SEL_NONE;
    end else begin
      sel_q <= sel_d;
      if (wr_en_i) begin
        trc_a_q <= wr_addr_i;
        trc_d_q <= wr_data_i;
      end
    end
  end

  always_comb begin
    case (sel_q)
      SEL_MEM: rd_data_o = mem_q;
      SEL_TA:  rd_data_o = trc_a_q;
      SEL_TD:  rd_data_o = trc_d_q;
      default: rd_data_o = '0;
    endcase
  end

  // R5: trace registers follow every committed write
  assert_trace_capture_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (trc_a_q == $past(wr_addr_i)) && (trc_d_q == $past(wr_data_i)));
  // R5: trace registers hold without a write
  assert_trace_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(trc_a_q) && $stable(trc_d_q));
  // R9: unmapped addresses read as zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, rd_addr_i} >= DEPTH_V && rd_addr_i != TRC_ADDR_LOC &&
     rd_addr_i != TRC_DATA_LOC) |=> (rd_data_o == '0));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter logic [7:0] TRC_ADDR_LOC = 8'hFE,
  parameter logic [7:0] TRC_DATA_LOC = 8'hFF
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o
);
  logic [2:0]        sync_q;
  logic              sclk_s, cs_n_s, mosi_s, sclk_d;
  logic              rise, fall, active;
  logic [BYTE_W-1:0] rd_addr, rd_data, wr_addr, wr_data;
  logic              wr_en;

  spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sclk_i, cs_n_i, mosi_i}),
    .q_o (sync_q)
  );

  assign {sclk_s, cs_n_s, mosi_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;
  assign active = ~cs_n_s;

  spi_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .active_i  (active),
    .rise_i    (rise),
    .fall_i    (fall),
    .mosi_i    (mosi_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .miso_o    (miso_o),
    .oe_o      (miso_oe_o)
  );

  spi_reg_bank #(
    .DEPTH        (DEPTH),
    .TRC_ADDR_LOC (TRC_ADDR_LOC),
    .TRC_DATA_LOC (TRC_DATA_LOC)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  // R4: deselect releases the output line
  assert_release_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !active |=> !miso_oe_o);
endmodule

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;
  localparam int HP = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  int checks = 0, errors = 0;
  logic [7:0] shadow [DEPTH];
  logic [7:0] last_ta = 8'h00, last_td = 8'h00;

  always #5 clk = ~clk;

  spi_reg_slave #(.DEPTH(DEPTH)) u_spi_reg_slave (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n),
    .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one frame of nbits; returns read byte and counts of enable/stability faults
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] adr,
                      input logic [7:0] dat, input int nbits,
                      output logic [7:0] rd, output int oe_bad, output int stab_bad);
    logic [23:0] word;
    logic        pre;
    word = {cmd, adr, dat};
    rd = '0; oe_bad = 0; stab_bad = 0;
    cs_n = 1'b0;
    wait_n(HP);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[23-i];
      wait_n(HP);
      pre = miso;
      if (miso_oe !== ((cmd == 8'h03) && i >= 16)) oe_bad++;
      if (i >= 16) rd = {rd[6:0], miso};
      sclk = 1'b1;
      wait_n(HP);
      if (cmd == 8'h03 && i >= 16 && miso !== pre) stab_bad++;
      sclk = 1'b0;
    end
    wait_n(HP);
    if (miso_oe !== 1'b0) oe_bad++;
    cs_n = 1'b1;
    wait_n(HP);
    if (miso_oe !== 1'b0) oe_bad++;
  endtask

  task automatic do_write(input logic [7:0] adr, input logic [7:0] dat, input string req);
    logic [7:0] rd; int ob, sb;
    xfer(8'h02, adr, dat, 24, rd, ob, sb);
    chk({req, "/R4 write enable"}, ob, 0);
    last_ta = adr; last_td = dat;
    if (adr < DEPTH) shadow[adr] = dat;
  endtask

  task automatic do_read(input logic [7:0] adr, input logic [7:0] exp, input string req);
    logic [7:0] rd; int ob, sb;
    xfer(8'h03, adr, 8'h00, 24, rd, ob, sb);
    chk({req, " read"}, rd, exp);
    chk({req, "/R4 read enable"}, ob, 0);
    chk({req, "/R3 falling-edge hold"}, sb, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd; int ob, sb;
    wait_n(6);
    rst = 1'b0;
    wait_n(4);
    chk("R1 oe after reset", miso_oe, 0);
    do_read(8'hFE, 8'h00, "R1 trace addr");
    do_read(8'hFF, 8'h00, "R1 trace data");

    // R2/R5: sweep every bank address, check trace after each write
    for (int a = 0; a < DEPTH; a++) begin
      do_write(8'(a), 8'((a * 37 + 5) & 8'hFF), "R2");
      do_read(8'hFE, last_ta, "R5 trace addr");
      do_read(8'hFF, last_td, "R5 trace data");
    end
    // R3: read back all with distinct patterns
    for (int a = 0; a < DEPTH; a++) do_read(8'(a), shadow[a], "R3");
    for (int a = 0; a < DEPTH; a += 5) begin
      do_write(8'(a), ~shadow[a], "R2 invert");
      do_read(8'(a), shadow[a], "R3 invert");
    end

    // R6: writes aimed at trace locations
    do_write(8'hFE, 8'h99, "R6");
    do_read(8'hFE, 8'hFE, "R6 trace addr");
    do_read(8'hFF, 8'h99, "R6 trace data");
    do_write(8'hFF, 8'h3C, "R6");
    do_read(8'hFE, 8'hFF, "R6 trace addr");
    do_read(8'hFF, 8'h3C, "R6 trace data");
    do_read(8'h0E, shadow[14], "R6 bank intact");
    do_read(8'h0F, shadow[15], "R6 bank intact");

    // R7: unknown commands
    for (int k = 0; k < 6; k++) begin
      logic [7:0] c;
      c = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h04 :
          (k == 3) ? 8'h83 : (k == 4) ? 8'hFF : 8'h12;
      xfer(c, 8'h03, 8'hA5, 24, rd, ob, sb);
      chk("R7 oe stays low", ob, 0);
      do_read(8'h03, shadow[3], "R7 bank unchanged");
      do_read(8'hFE, last_ta, "R7 trace addr unchanged");
      do_read(8'hFF, last_td, "R7 trace data unchanged");
    end

    // R8: aborted writes at several lengths
    for (int n = 4; n < 24; n += 5) begin
      xfer(8'h02, 8'h05, 8'h5A, n, rd, ob, sb);
      do_read(8'h05, shadow[5], "R8 no update");
      do_read(8'hFE, last_ta, "R8 trace addr");
      do_read(8'hFF, last_td, "R8 trace data");
    end
    do_write(8'h05, 8'h6B, "R8 next frame");
    do_read(8'h05, 8'h6B, "R8 next frame");

    // R9: unmapped addresses
    do_write(8'h40, 8'h77, "R9");
    do_read(8'hFE, 8'h40, "R9 trace addr");
    do_read(8'hFF, 8'h77, "R9 trace data");
    do_read(8'h40, 8'h00, "R9 unmapped read");
    do_read(8'h00, shadow[0], "R9 no alias");
    do_read(8'h10, 8'h00, "R9 first unmapped");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule